// File: doc/BRIEF.md
# Warbling Ringer Tone Generator

This block turns an 8 kHz frame-sync strobe into a two-tone warbling square wave that drives a piezo sounder through a pair of complementary outputs. Each tone is a whole number of frame ticks per half period. The generator switches between the two tones of the selected combination at a slow warble rate, and that rate also depends on the combination.

The tone combination comes from one of two sources. The first is a two-bit code from board pins. The second is a three-bit code written by a processor register, which offers six combinations. A two-bit volume code shortens the high time of each drive pulse, and the generator measures the spacing between ticks in system clocks to set that width. Changes to the combination or to the enable are held back until the current warble segment ends, so the sounder never receives a broken tone.

Top module: `ringer_tone_gen`

## Requirements
- R1: After reset both drive outputs are low and the generator is idle. The first warble boundary comes after 250 frame ticks, and no pulse appears before it even with the enable high.
- R2: When `sel_from_reg` is 0, `pin_code` picks the combination:
  - 0 and 3 give 1000/1333 Hz with 250-tick segments.
  - 1 gives 800/1000 Hz with 250-tick segments.
  - 2 gives 800/1000 Hz with 500-tick segments.
- R3: When `sel_from_reg` is 1, `reg_code` picks the combination and `pin_code` has no effect:
  - 0, 1 and 2 match pin codes 0, 1 and 2.
  - 3 gives 1333/2000 Hz with 250-tick segments.
  - 4 gives 800/1333 Hz with 500-tick segments.
  - 5 is listed in R10.
  - 6 and 7 act as 0.
- R4: Each tone's half period is a fixed number of ticks: 2000 Hz is 2, 1333 Hz is 3, 1000 Hz is 4 and 800 Hz is 5. A drive pulse rises once every two half periods.
- R5: At each warble boundary the generator moves to the other tone of the combination. The first tone listed is used after any change of combination or enable.
- R6: Each pulse is high for (H×G)>>(3−`ring_vol`) system clocks, where H is the half period in ticks and G is the measured tick spacing in clocks. Volume 3 gives 50% duty, and volumes 2, 1 and 0 give 25%, 12.5% and 6.25%.
- R7: While active, `ring_n` is the inverse of `ring_p`. While inactive, both outputs are low, and they are never high together.
- R8: A new combination or enable value is adopted only at a warble boundary. At that boundary the tone phase restarts with a rising pulse when the generator is enabled.
- R9: Without frame ticks the tone counters stay frozen and no new pulse starts.
- R10: Register code 5 gives a steady 1000 Hz tone in 250-tick segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-clock strobe at the 8 kHz frame rate |
| ring_en | input | 1 | Requests ringing; adopted at the next warble boundary |
| sel_from_reg | input | 1 | 1 selects the register code, 0 the pin code |
| pin_code | input | 2 | Combination code from board pins |
| reg_code | input | 3 | Combination code from the processor register |
| ring_vol | input | 2 | Volume level, 3 loudest |
| ring_p | output | 1 | Sounder drive, true phase |
| ring_n | output | 1 | Sounder drive, inverted phase |

## Verification
The assertions check these properties on every cycle:
- the two outputs are never high together, and both stay low while inactive;
- a pulse request only follows a tick;
- the tone counter stays frozen between ticks;
- the warble counter stays in range;
- the active combination changes only at a segment start.

Some behaviour only the bench's scenarios can show. These are the exact pulse widths for each volume, the spacing between pulses for every combination, and the alternation of tones across segments. They also include the delay of a mid-segment change until the boundary, and the silence once ticks stop. The bench shows them by comparing every observed pulse with one predicted from the requirements.

// File: rtl/ringer_pkg.sv
// Shared types for the ringer tone generator: combination identifiers and
// the per-combination timing record (half periods in frame ticks, warble length).
package ringer_pkg;

    typedef enum logic [2:0] {
        TC_A = 3'd0,   // 1000 / 1333 Hz, short segments
        TC_B = 3'd1,   // 800 / 1000 Hz, short segments
        TC_C = 3'd2,   // 800 / 1000 Hz, long segments
        TC_D = 3'd3,   // 1333 / 2000 Hz, short segments
        TC_E = 3'd4,   // 800 / 1333 Hz, long segments
        TC_F = 3'd5    // steady 1000 Hz
    } tone_id_e;

    typedef struct packed {
        logic [2:0] half_a;       // half period of first tone, in ticks
        logic [2:0] half_b;       // half period of second tone, in ticks
        logic       long_seg;     // 1: long warble segment
    } tone_cfg_t;

    // Timing record of one combination.
    function automatic tone_cfg_t tone_params(input tone_id_e id);
        tone_cfg_t c;
        c.half_a   = 3'd4;
        c.half_b   = 3'd3;
        c.long_seg = 1'b0;
        case (id)
            TC_B: begin c.half_a = 3'd5; c.half_b = 3'd4; c.long_seg = 1'b0; end
            TC_C: begin c.half_a = 3'd5; c.half_b = 3'd4; c.long_seg = 1'b1; end
            TC_D: begin c.half_a = 3'd3; c.half_b = 3'd2; c.long_seg = 1'b0; end
            TC_E: begin c.half_a = 3'd5; c.half_b = 3'd3; c.long_seg = 1'b1; end
            TC_F: begin c.half_a = 3'd4; c.half_b = 3'd4; c.long_seg = 1'b0; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ringer_combo_sel.sv
// Chooses the requested tone combination from either the pin code or the
// register code. Purely combinational; assumes both codes are already
// synchronous to clk.
module ringer_combo_sel
    import ringer_pkg::*;
(
    input  logic       sel_from_reg,
    input  logic [1:0] pin_code,
    input  logic [2:0] reg_code,
    output tone_id_e   want_id
);

    // Map the selected source code onto a combination identifier.
    always_comb begin
        want_id = TC_A;
        if (sel_from_reg) begin
            case (reg_code)
                3'd1:    want_id = TC_B;
                3'd2:    want_id = TC_C;
                3'd3:    want_id = TC_D;
                3'd4:    want_id = TC_E;
                3'd5:    want_id = TC_F;
                default: want_id = TC_A;
            endcase
        end else begin
            case (pin_code)
                2'd1:    want_id = TC_B;
                2'd2:    want_id = TC_C;
                default: want_id = TC_A;
            endcase
        end
    end

endmodule

// File: rtl/ringer_sequencer.sv
// Frame-tick sequencer: counts warble segments and tone half periods,
// adopts a new combination and enable only at segment boundaries, and issues
// a one-clock rise request at the start of every high half period.
// Assumes frame_tick is a single-clock strobe.
module ringer_sequencer
    import ringer_pkg::*;
#(
    parameter int SHORT_TICKS = 250,
    parameter int LONG_TICKS  = 500,
    localparam int WARB_W     = $clog2(LONG_TICKS + 1)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic              want_en,
    input  tone_id_e          want_id,
    output logic              rise_req,
    output logic [2:0]        half_ticks,
    output logic              active,
    output tone_id_e          act_id,
    output logic [WARB_W-1:0] warb_cnt,
    output logic [WARB_W-1:0] warb_len,
    output logic [2:0]        tone_cnt
);

    localparam logic [WARB_W-1:0] SHORT_L = WARB_W'(SHORT_TICKS);
    localparam logic [WARB_W-1:0] LONG_L  = WARB_W'(LONG_TICKS);

    tone_cfg_t cfg;
    logic      half_sel;
    logic      phase_hi;
    logic      seg_end;
    logic      same_key;

    // Decode the timing of the active combination and the current half period.
    always_comb begin
        cfg        = tone_params(act_id);
        warb_len   = cfg.long_seg ? LONG_L : SHORT_L;
        half_ticks = half_sel ? cfg.half_b : cfg.half_a;
        seg_end    = (warb_cnt == warb_len - WARB_W'(1));
        same_key   = (want_en == active) && (want_id == act_id);
    end

    // Advance segment and tone counters once per frame tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warb_cnt <= '0;
            tone_cnt <= '0;
            act_id   <= TC_A;
            active   <= 1'b0;
            half_sel <= 1'b0;
            phase_hi <= 1'b0;
            rise_req <= 1'b0;
        end else begin
            rise_req <= 1'b0;
            if (frame_tick) begin
                if (seg_end) begin
                    warb_cnt <= '0;
                    act_id   <= want_id;
                    active   <= want_en;
                    half_sel <= same_key ? ~half_sel : 1'b0;
                    tone_cnt <= '0;
                    phase_hi <= 1'b1;
                    rise_req <= want_en;
                end else begin
                    warb_cnt <= warb_cnt + WARB_W'(1);
                    if (tone_cnt == half_ticks - 3'd1) begin
                        tone_cnt <= '0;
                        phase_hi <= ~phase_hi;
                        rise_req <= active & ~phase_hi;
                    end else begin
                        tone_cnt <= tone_cnt + 3'd1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ringer_pulse_shaper.sv
// Pulse shaper: measures the tick spacing in system clocks and, on each rise
// request, drives a pulse whose width is the half period scaled down by the
// volume code. Assumes ticks arrive at a steady spacing below 2**GAP_W clocks.
module ringer_pulse_shaper #(
    parameter int GAP_W   = 16,
    localparam int PROD_W = GAP_W + 3
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic       rise_req,
    input  logic [2:0] half_ticks,
    input  logic [1:0] ring_vol,
    output logic       drive
);

    logic [GAP_W-1:0]  gap_cnt;
    logic [GAP_W-1:0]  gap_q;
    logic [PROD_W-1:0] full_w;
    logic [PROD_W-1:0] pulse_w;
    logic [PROD_W-1:0] width_cnt;
    logic [1:0]        shift;

    // Scale the half period in clocks by the volume level.
    always_comb begin
        full_w  = PROD_W'(half_ticks) * PROD_W'(gap_q);
        shift   = 2'd3 - ring_vol;
        pulse_w = full_w >> shift;
        drive   = (width_cnt != '0);
    end

    // Measure clocks between successive frame ticks, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            gap_q   <= '0;
        end else if (frame_tick) begin
            gap_q   <= gap_cnt;
            gap_cnt <= GAP_W'(1);
        end else if (gap_cnt != '1) begin
            gap_cnt <= gap_cnt + GAP_W'(1);
        end
    end

    // Load the pulse width on a rise request and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_cnt <= '0;
        end else if (rise_req) begin
            width_cnt <= pulse_w;
        end else if (width_cnt != '0) begin
            width_cnt <= width_cnt - PROD_W'(1);
        end
    end

endmodule

// File: rtl/ringer_tone_gen.sv
// Top of the warbling ringer: selects the combination source, sequences the
// warble and tone phases from frame ticks, shapes volume-scaled pulses and
// forms the complementary sounder drive (low-low while inactive).
// Assumes all inputs are synchronous to clk.
module ringer_tone_gen
    import ringer_pkg::*;
#(
    parameter int SHORT_TICKS = 250,
    parameter int LONG_TICKS  = 500,
    parameter int GAP_W       = 16
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_tick,
    input  logic       ring_en,
    input  logic       sel_from_reg,
    input  logic [1:0] pin_code,
    input  logic [2:0] reg_code,
    input  logic [1:0] ring_vol,
    output logic       ring_p,
    output logic       ring_n
);

    localparam int WARB_W = $clog2(LONG_TICKS + 1);

    tone_id_e          want_id;
    tone_id_e          seq_id;
    logic              seq_rise;
    logic              seq_active;
    logic [2:0]        seq_half;
    logic [WARB_W-1:0] seq_warb;
    logic [WARB_W-1:0] seq_wlen;
    logic [2:0]        seq_tone;
    logic              shp_drive;

    ringer_combo_sel u_sel (
        .sel_from_reg (sel_from_reg),
        .pin_code     (pin_code),
        .reg_code     (reg_code),
        .want_id      (want_id)
    );

    ringer_sequencer #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .want_en    (ring_en),
        .want_id    (want_id),
        .rise_req   (seq_rise),
        .half_ticks (seq_half),
        .active     (seq_active),
        .act_id     (seq_id),
        .warb_cnt   (seq_warb),
        .warb_len   (seq_wlen),
        .tone_cnt   (seq_tone)
    );

    ringer_pulse_shaper #(
        .GAP_W (GAP_W)
    ) u_shp (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .rise_req   (seq_rise),
        .half_ticks (seq_half),
        .ring_vol   (ring_vol),
        .drive      (shp_drive)
    );

    // Gate the drive with the active state and form the inverted phase.
    always_comb begin
        ring_p = seq_active & shp_drive;
        ring_n = seq_active & ~shp_drive;
    end

endmodule

// File: rtl/ringer_checker.sv
// Assertion checker for ringer_tone_gen, attached by the bind below.
// Observes the outputs and the sequencer state; drives nothing.
module ringer_checker #(
    parameter int WARB_W = 9
)(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              act_en,
    input logic              rise,
    input logic              drv_p,
    input logic              drv_n,
    input logic [WARB_W-1:0] warb_cnt,
    input logic [WARB_W-1:0] warb_len,
    input logic [2:0]        tone_cnt,
    input logic [2:0]        act_id
);

    assert_never_both_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_p && drv_n));

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !act_en |-> (!drv_p && !drv_n));

    assert_rise_only_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> act_en);

    assert_rise_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(tick));

    assert_tone_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tone_cnt));

    assert_segment_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        warb_cnt < warb_len);

    assert_cfg_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_id) |-> (warb_cnt == '0));

endmodule

bind ringer_tone_gen ringer_checker #(.WARB_W(WARB_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (frame_tick),
    .act_en   (seq_active),
    .rise     (seq_rise),
    .drv_p    (ring_p),
    .drv_n    (ring_n),
    .warb_cnt (seq_warb),
    .warb_len (seq_wlen),
    .tone_cnt (seq_tone),
    .act_id   (seq_id)
);

// File: tb/ringer_tone_gen_bench.sv
module ringer_tone_gen_bench;

    localparam int G = 8;   // clocks between frame ticks

    typedef struct {
        int    start;
        int    width;
        string tag;
    } pulse_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_tick = 1'b0;
    logic       ring_en = 1'b0;
    logic       sel_from_reg = 1'b0;
    logic [1:0] pin_code = 2'd0;
    logic [2:0] reg_code = 3'd0;
    logic [1:0] ring_vol = 2'd3;
    logic       ring_p;
    logic       ring_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    pulse_t exp_q[$];
    pulse_t obs_q[$];

    always #2 clk = ~clk;

    ringer_tone_gen u_ringer_tone_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_tick   (frame_tick),
        .ring_en      (ring_en),
        .sel_from_reg (sel_from_reg),
        .pin_code     (pin_code),
        .reg_code     (reg_code),
        .ring_vol     (ring_vol),
        .ring_p       (ring_p),
        .ring_n       (ring_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // ---------------- reference model (from the requirements) ----------------
    function automatic int pick_combo();
        if (sel_from_reg) begin
            case (reg_code)
                3'd1: return 1;
                3'd2: return 2;
                3'd3: return 3;
                3'd4: return 4;
                3'd5: return 5;
                default: return 0;
            endcase
        end
        case (pin_code)
            2'd1: return 1;
            2'd2: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic int half_of(input int id, input int second);
        int a, b;
        case (id)
            1, 2: begin a = 5; b = 4; end
            3:    begin a = 3; b = 2; end
            4:    begin a = 5; b = 3; end
            5:    begin a = 4; b = 4; end
            default: begin a = 4; b = 3; end
        endcase
        return second ? b : a;
    endfunction

    function automatic int seg_of(input int id);
        return (id == 2 || id == 4) ? 500 : 250;
    endfunction

    int m_id = 0, m_en = 0, m_half = 0, m_phase = 0, m_tone = 0, m_warb = 0;
    int gtick = 0;
    int ps = 0, pe = 0;
    bit hp = 1'b0;
    string cur_tag = "R1";

    task automatic note_rise(input int t, input int h);
        int w, s;
        w = (h * G) >> (3 - int'(ring_vol));
        if (w == 0) return;
        s = t * G + 1;
        if (hp && s <= pe) begin
            pe = s + w;
        end else begin
            if (hp) exp_q.push_back('{ps, pe - ps, cur_tag});
            ps = s;
            pe = s + w;
            hp = 1'b1;
        end
    endtask

    task automatic model_tick(input int t);
        int nid, nen, h;
        nid = pick_combo();
        nen = int'(ring_en);
        if (m_warb == seg_of(m_id) - 1) begin
            if (m_en == 1 && nen == 0 && hp && pe > t * G) pe = t * G;
            m_half  = (nid == m_id && nen == m_en) ? 1 - m_half : 0;
            m_id    = nid;
            m_en    = nen;
            m_warb  = 0;
            m_tone  = 0;
            m_phase = 1;
            if (m_en == 1) note_rise(t, half_of(m_id, m_half));
        end else begin
            m_warb++;
            h = half_of(m_id, m_half);
            if (m_tone == h - 1) begin
                m_tone = 0;
                if (m_phase == 0 && m_en == 1) note_rise(t, h);
                m_phase = 1 - m_phase;
            end else begin
                m_tone++;
            end
        end
    endtask

    // Driver: predicts each tick, then applies it.
    task automatic run_ticks(input int n, input string tag);
        cur_tag = tag;
        for (int i = 0; i < n; i++) begin
            model_tick(gtick);
            gtick++;
            @(negedge clk) frame_tick = 1'b1;
            @(negedge clk) frame_tick = 1'b0;
            repeat (G - 2) @(negedge clk);
        end
    endtask

    // ---------------- monitor and scoreboard ----------------
    int  cyc = 0;
    bit  in_pulse = 1'b0;
    int  st = 0, wd = 0;
    bit  have_prev = 1'b0;
    int  prev_obs = 0, prev_exp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ring_p && !in_pulse) begin
                in_pulse = 1'b1; st = cyc; wd = 1;
            end else if (ring_p) begin
                wd++;
            end else if (in_pulse) begin
                obs_q.push_back('{st, wd, ""});
                in_pulse = 1'b0;
            end
        end
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            pulse_t e, o;
            e = exp_q.pop_front();
            o = obs_q.pop_front();
            check(o.width == e.width, e.tag, "pulse width", o.width, e.width);
            if (have_prev)
                check(o.start - prev_obs == e.start - prev_exp, e.tag,
                      "pulse spacing", o.start - prev_obs, e.start - prev_exp);
            have_prev = 1'b1;
            prev_obs  = o.start;
            prev_exp  = e.start;
        end
    end

    // ---------------- scenario ----------------
    initial begin
        repeat (4) @(negedge clk);
        check(ring_p == 1'b0 && ring_n == 1'b0, "R1", "outputs in reset", {ring_p, ring_n}, 0);
        rst_n   = 1'b1;
        ring_en = 1'b1;
        @(negedge clk);
        check(ring_p == 1'b0 && ring_n == 1'b0, "R1", "outputs after reset", {ring_p, ring_n}, 0);

        run_ticks(240, "R1");
        check(obs_q.size() == 0 && ring_p == 1'b0, "R1", "pulses before boundary", obs_q.size(), 0);
        run_ticks(760, "R4");
        check(ring_n == !ring_p, "R7", "complement", ring_n, !ring_p);

        ring_vol = 2'd0; run_ticks(500, "R6");
        ring_vol = 2'd1; run_ticks(500, "R6");
        ring_vol = 2'd2;
        pin_code = 2'd1; run_ticks(500, "R2");
        pin_code = 2'd2; run_ticks(1500, "R5");
        pin_code = 2'd3; run_ticks(500, "R2");
        check(ring_n == !ring_p, "R7", "complement", ring_n, !ring_p);

        ring_vol = 2'd3;
        sel_from_reg = 1'b1;
        reg_code = 3'd3; run_ticks(1000, "R3");
        reg_code = 3'd4; run_ticks(1500, "R3");
        reg_code = 3'd5; run_ticks(750, "R10");
        reg_code = 3'd6; run_ticks(500, "R3");
        reg_code = 3'd0; pin_code = 2'd2; run_ticks(750, "R3");

        run_ticks(125, "R8");
        reg_code = 3'd4; ring_vol = 2'd1; run_ticks(1000, "R8");

        ring_en = 1'b0; run_ticks(300, "R7");
        check(ring_p == 1'b0 && ring_n == 1'b0, "R7", "idle outputs", {ring_p, ring_n}, 0);
        run_ticks(300, "R7");
        check(ring_p == 1'b0 && ring_n == 1'b0, "R7", "idle outputs", {ring_p, ring_n}, 0);

        ring_en = 1'b1; run_ticks(600, "R7");
        check(ring_n == !ring_p, "R7", "complement", ring_n, !ring_p);

        repeat (300) @(negedge clk);
        check(ring_p == 1'b0, "R9", "drive without ticks", ring_p, 0);
        repeat (1500) @(negedge clk);
        check(ring_p == 1'b0, "R9", "drive without ticks", ring_p, 0);

        if (hp) begin exp_q.push_back('{ps, pe - ps, cur_tag}); hp = 1'b0; end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9", "missing pulses", exp_q.size(), 0);
        check(obs_q.size() == 0, "R9", "unexpected pulses", obs_q.size(), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule